// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block samples 48 digital input lines and presents them to a simple 8-bit I/O bus as six byte-wide read ports inside an 8-byte address window. The lines are grouped in eights: line n sits in group n/8 at bit n mod 8. Groups 0, 1 and 2 answer at byte offsets 0, 1 and 2. Groups 3, 4 and 5 answer at offsets 4, 5 and 6. Offset 3 holds no data.

Each group watches its eight lines for a transition in either direction. When a group that software has enabled sees a change, the block latches a status flag for that group and raises a level interrupt request. The request stays up until software reads the combined control/status register at offset 7. Writing offset 7 loads the per-group enable mask. Reading offset 7 returns the latched group flags and an active-low interrupt flag, and then clears the flags.

Top module: `cos_input_port`

## Requirements
- R1: After reset, `rdata_o` is 0, `irq_o` is 0, every group is disabled and no status flag is set.
- R2: A read at offset 0, 1 or 2 returns input group 0, 1 or 2. A read at offset 4, 5 or 6 returns group 3, 4 or 5. Line n of a group appears at bit n mod 8. A read at offset 3 returns 0x00.
- R3: Inputs pass through a two-stage synchroniser. A read whose bus cycle starts in the cycle where a line changes, or one cycle later, returns the old value. A read that starts two cycles after the change returns the new value.
- R4: Both a rising and a falling transition on any line of an enabled group set that group's status flag.
- R5: A transition in a group whose enable bit is 0 sets no status flag and raises no interrupt.
- R6: A write to offset 7 loads enable bit k from data bit k, for k from 0 to 5. Data bits 7 and 6 have no effect.
- R7: A read at offset 7 returns the group status flags in bits 5:0. Bit 6 is 0 when an interrupt is pending and 1 otherwise. Bit 7 is always 0.
- R8: A read at offset 7 clears every status flag, which drops `irq_o` on the following cycle.
- R9: A change detected in the same cycle as an offset-7 read is kept, and it shows up in the next offset-7 read.
- R10: Writes to offsets 0 through 6 change neither the enable mask nor any status flag.
- R11: `irq_o` is high exactly while at least one status flag is set. It does not drop on its own.
- R12: `rdata_o` is registered. It updates on the clock edge that accepts a read and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | 48 | Asynchronous digital input lines |
| addr_i | input | 3 | Byte offset within the window |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A line change made at a falling edge passes three rising edges before it sets a status flag and `irq_o`: the two synchroniser stages, then the status register. A read issued at a falling edge is captured at the next rising edge, and `rdata_o` is sampled at the falling edge after that. The bench therefore waits four falling edges after each input change before it checks the interrupt or the status, so every register on the path has settled. The latency check (R3) and the same-cycle retention check (R9) place their reads on exact edges counted from the change, and their expected values follow that edge count.

// File: rtl/cos_pkg.sv
package cos_pkg;
    localparam int unsigned BUS_W      = 8;
    localparam int unsigned NUM_GROUPS = 6;
    localparam int unsigned ADDR_W     = 3;
    localparam int unsigned NUM_LINES  = NUM_GROUPS * BUS_W;
    localparam logic [ADDR_W-1:0] CTRL_OFFSET = 3'd7;
    localparam int unsigned IRQ_N_BIT  = 6;

    // Byte offset at which a group is read: groups above 2 skip offset 3.
    function automatic logic [ADDR_W-1:0] group_offset(input int unsigned g);
        return (g < 3) ? ADDR_W'(g) : ADDR_W'(g + 1);
    endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/cos_edge_detect.sv
module cos_edge_detect #(
    parameter int unsigned GW     = 8,
    parameter int unsigned GROUPS = 6,
    localparam int unsigned W     = GW * GROUPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      sample_i,
    output logic [GROUPS-1:0] grp_chg_o
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_t;

    edge_t st_d, st_q;
    logic [W-1:0] diff;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sample_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign diff = sample_i ^ st_q.prev;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_chg_o[g] = |diff[g*GW +: GW];
    end
endmodule

// File: rtl/cos_group_status.sv
module cos_group_status #(
    parameter int unsigned GROUPS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_load_i,
    input  logic [GROUPS-1:0] en_data_i,
    input  logic              clear_i,
    input  logic [GROUPS-1:0] grp_chg_i,
    output logic [GROUPS-1:0] enable_o,
    output logic [GROUPS-1:0] status_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [GROUPS-1:0] enable;
        logic [GROUPS-1:0] status;
    } gstat_t;

    gstat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_load_i) st_d.enable = en_data_i;
        // a change arriving with the clearing read survives it
        st_d.status = (clear_i ? '0 : st_q.status) | (grp_chg_i & st_q.enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o = st_q.enable;
    assign status_o = st_q.status;
    assign irq_o    = |st_q.status;
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
    import cos_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pins_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic [BUS_W-1:0]     wdata_i,
    output logic [BUS_W-1:0]     rdata_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } top_t;

    logic [NUM_LINES-1:0]  sample_w;
    logic [NUM_GROUPS-1:0] grp_chg_w;
    logic [NUM_GROUPS-1:0] enable_w;
    logic [NUM_GROUPS-1:0] status_w;
    logic                  irq_w;
    logic                  ctrl_rd, ctrl_wr;
    logic [BUS_W-1:0]      rd_value;
    top_t                  st_d, st_q;

    assign ctrl_rd = rd_i && (addr_i == CTRL_OFFSET);
    assign ctrl_wr = wr_i && (addr_i == CTRL_OFFSET);

    cos_sync #(.W(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (sample_w)
    );

    cos_edge_detect #(.GW(BUS_W), .GROUPS(NUM_GROUPS)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample_w),
        .grp_chg_o (grp_chg_w)
    );

    cos_group_status #(.GROUPS(NUM_GROUPS)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_load_i (ctrl_wr),
        .en_data_i (wdata_i[NUM_GROUPS-1:0]),
        .clear_i   (ctrl_rd),
        .grp_chg_i (grp_chg_w),
        .enable_o  (enable_w),
        .status_o  (status_w),
        .irq_o     (irq_w)
    );

    always_comb begin
        rd_value = '0;
        if (addr_i == CTRL_OFFSET) begin
            rd_value[NUM_GROUPS-1:0] = status_w;
            rd_value[IRQ_N_BIT]      = ~irq_w;
        end else begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (addr_i == group_offset(g)) rd_value = sample_w[g*BUS_W +: BUS_W];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_i) st_d.rdata = rd_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign irq_o   = irq_w;
endmodule

// File: rtl/cos_input_port_chk.sv
module cos_input_port_chk
    import cos_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     addr_i,
    input logic                  rd_i,
    input logic                  wr_i,
    input logic [BUS_W-1:0]      wdata_i,
    input logic [BUS_W-1:0]      rdata_o,
    input logic                  irq_o,
    input logic [NUM_GROUPS-1:0] enable,
    input logic [NUM_GROUPS-1:0] status,
    input logic [NUM_GROUPS-1:0] chg
);
    // R7: the interrupt flag read back is the inverse of the pending state
    a_r7_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == CTRL_OFFSET) |=> (rdata_o[IRQ_N_BIT] == ($past(status) == '0)) && !rdata_o[7]);

    // R8: a read with no new change leaves nothing pending
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == CTRL_OFFSET && (chg & enable) == '0) |=> !irq_o);

    // R4: an enabled change raises the request
    a_r4_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg & enable) != '0) |=> irq_o);

    // R5: with no enabled change and no request, nothing rises
    a_r5_quiet_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && (chg & enable) == '0) |=> !irq_o);

    // R6: enable load from the written byte
    a_r6_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == CTRL_OFFSET) |=> enable == $past(wdata_i[NUM_GROUPS-1:0]));

    // R10: writes elsewhere leave the mask alone
    a_r10_other_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i != CTRL_OFFSET) |=> $stable(enable));

    // R11: request holds until a status read
    a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(rd_i && addr_i == CTRL_OFFSET)) |=> irq_o);

    // R12: read data holds without a read
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

    // R2: the gap offset reads zero
    a_r2_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == 3'd3) |=> rdata_o == '0);
endmodule

bind cos_input_port cos_input_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .enable  (enable_w),
    .status  (status_w),
    .chg     (grp_chg_w)
);

// File: tb/cos_input_port_bench.sv
module cos_input_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] pins = '0;
    logic [2:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int total = 0, bad = 0;
    logic [5:0] m_status = '0;
    logic [5:0] m_en = '0;

    always #10 clk = ~clk;

    cos_input_port u_cos_input_port (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .addr_i(addr),
        .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [7:0] exp_data(input logic [2:0] a, input logic [47:0] p);
        if (a == 3'd3) return 8'h00;
        if (a < 3'd3) return p[a*8 +: 8];
        return p[(a-1)*8 +: 8];
    endfunction

    function automatic logic [7:0] exp_ctrl(input logic [5:0] s);
        return {1'b0, (s == 6'd0), s};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_pins(input logic [47:0] np);
        for (int g = 0; g < 6; g++)
            if (pins[g*8 +: 8] != np[g*8 +: 8] && m_en[g]) m_status[g] = 1'b1;
        pins = np;
        settle();
    endtask

    task automatic read_ctrl(input string req);
        logic [7:0] d;
        bus_read(3'd7, d);
        check(req, d, exp_ctrl(m_status));
        m_status = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d, hold;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata", rdata, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        read_ctrl("R1 status");

        // R5: changes while all groups disabled
        set_pins(48'hA5A5_5A5A_F00F);
        check("R5 irq", {7'd0, irq}, 8'h00);
        read_ctrl("R5 status");

        // R2: every data offset and the gap
        for (int a = 0; a < 7; a++) begin
            bus_read(3'(a), d);
            check("R2 data port", d, exp_data(3'(a), pins));
        end

        // R6: write with upper bits set
        bus_write(3'd7, 8'hFF);
        m_en = 6'h3F;
        // R4 rising edge on group 1 bit 3
        set_pins(pins | 48'h0000_0000_0800 & ~pins);
        if (!pins[11]) begin pins[11] = 1'b1; settle(); m_status[1] = 1'b1; end
        check("R11 irq set", {7'd0, irq}, 8'h01);
        read_ctrl("R4 rise status");
        check("R8 irq clear", {7'd0, irq}, 8'h00);
        read_ctrl("R8 second read");
        // R4 falling edge
        set_pins(pins & ~48'h0000_0000_0800);
        read_ctrl("R4 fall status");

        // R10: writes to data offsets ignored
        bus_write(3'd2, 8'h00);
        bus_write(3'd3, 8'h00);
        bus_write(3'd0, 8'h00);
        set_pins(pins ^ 48'h0100_0000_0000);
        check("R10 irq", {7'd0, irq}, 8'h01);
        read_ctrl("R10 status");

        // R6: partial mask, group 2 only
        bus_write(3'd7, 8'hC4);
        m_en = 6'h04;
        set_pins(pins ^ 48'h0000_0001_0101);
        read_ctrl("R6 partial mask");

        // R9: change detected in the cycle of the status read
        bus_write(3'd7, 8'h3F);
        m_en = 6'h3F;
        pins = pins ^ 48'h0000_0100_0000;
        @(negedge clk);
        @(negedge clk);
        bus_read(3'd7, d);
        check("R9 first read", d, 8'h40);
        @(negedge clk);
        bus_read(3'd7, d);
        check("R9 kept", d, 8'h08);
        check("R11 irq after clear", {7'd0, irq}, 8'h00);

        // R3: synchroniser latency on group 0
        hold = pins[7:0];
        pins[7:0] = ~hold;
        bus_read(3'd0, d);
        check("R3 edge 1 old", d, hold);
        bus_read(3'd0, d);
        check("R3 edge 2 old", d, hold);
        bus_read(3'd0, d);
        check("R3 edge 3 new", d, ~hold);
        m_status[0] = 1'b1;
        settle();
        read_ctrl("R3 status");

        // R12: hold without read
        bus_read(3'd1, hold);
        pins[15:8] = ~pins[15:8];
        repeat (5) @(negedge clk);
        check("R12 hold", rdata, hold);
        m_status[1] = 1'b1;
        read_ctrl("R12 status");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int unsigned op = $urandom_range(0, 9);
            if (op < 5) begin
                logic [47:0] np = pins;
                for (int g = 0; g < 6; g++)
                    if ($urandom_range(0, 2) == 0) np[g*8 +: 8] = 8'($urandom);
                set_pins(np);
                check("R11 irq random", {7'd0, irq}, {7'd0, (m_status != 0)});
            end else if (op == 5) begin
                logic [7:0] v = 8'($urandom);
                bus_write(3'd7, v);
                m_en = v[5:0];
            end else if (op == 6) begin
                bus_write(3'($urandom_range(0, 6)), 8'($urandom));
            end else if (op < 9) begin
                logic [2:0] a = 3'($urandom_range(0, 6));
                bus_read(a, d);
                check("R2 random data", d, exp_data(a, pins));
            end else begin
                read_ctrl("R4 random status");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule